// File: doc/BRIEF.md
# Controller Pad State Register Bank

This block turns two 32-bit button bitmaps into console-format pad words that bus software can read. Each bitmap arrives from a foreign clock domain and is active-high, one bit per button. Every bit passes through a chain of double-flop synchronizers into the local bus clock.

Sixteen of the synchronized bits are then permuted and inverted into a 16-bit active-low word. The low byte holds the direction pad, start, select and the stick-click buttons. The high byte holds the face and shoulder buttons. Bits above 15 are dropped on purpose. One of them is the overlay-menu button, which a host agent consumes and which must never reach the console side.

Software reads the two pad words and a fixed status word through a 32-bit request bus. The bus decodes a 256-byte window. Reads return one cycle after they are granted. Writes anywhere in the window are granted and change nothing.

Top module: `pad_reg_bank`

## Requirements
- R1: A request whose address lies within WIN_BYTES (default 256) bytes of WIN_BASE (default 0x1F80_8500) is granted in the same cycle (`gnt_o`=1). A request outside that window gets `gnt_o`=0.
- R2: A granted read raises `rvalid_o` for exactly the next cycle and carries its data on `rdata_o` in that cycle. When `rvalid_o` is low, `rdata_o` is 0, and no write or ungranted request produces `rvalid_o`.
- R3: Word offsets within the window map as follows. Offset 0x0 reads the player-1 word, 0x4 reads the player-2 word and 0x8 reads status. Every other word offset in the window reads 0. Each player's word depends only on that player's bitmap.
- R4: The status word always reads 0x0000_0001 (bit 0 = present), including in the first cycles after reset.
- R5: Pad bits [7:0], from bit 7 down to bit 0, are the inversions of input bits 1, 2, 0, 3, 4, 15, 14 and 5.
- R6: Pad bits [15:8], from bit 15 down to bit 8, are the inversions of input bits 8, 7, 9, 6, 11, 10, 13 and 12.
- R7: Pad registers read 0 in bits [31:16]. Input bits 16 to 31 have no effect, so with no bit 0..15 set a pad register reads 0x0000_FFFF.
- R8: A change on an input bitmap is seen by a read sampled at the third rising edge after the change. Reads sampled at the first and second edges still return the old value.
- R9: Writes at any offset in the window are granted, produce no `rvalid_o`, and leave all three readable registers unchanged.
- R10: While `rst_ni` is low, `rvalid_o` and `rdata_o` are 0. Reads sampled at the first SYNC_STAGES edges after reset release return 0 for the pad registers, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| p1_btn_i | input | 32 | Player-1 button bitmap, active-high, foreign clock domain |
| p2_btn_i | input | 32 | Player-2 button bitmap, active-high, foreign clock domain |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Write data (discarded) |
| gnt_o | output | 1 | Request accepted (in window) |
| rvalid_o | output | 1 | Read data valid, one cycle after a granted read |
| rdata_o | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: a 256-byte window at 0x1F80_8500 and two synchronizer stages. This is small enough to cover the design fully.

- **Window decode:** every one of the 64 word offsets is read and written, and addresses just outside the window on each side are tried.
- **Mapping:** all 32 single-bit patterns are swept on each player with the other player held at a distinct pattern. A run of pseudo-random bitmaps follows, with expected words computed arithmetically from the mapping rules.
- **Timing edges:** the two-stage setting makes the exact three-edge input latency and the post-reset fill window short enough to probe cycle by cycle.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int unsigned BTN_W  = 32;
  localparam int unsigned PAD_W  = 16;
  localparam int unsigned DATA_W = 32;

  // word indices inside the window; software-visible, fixed
  localparam int unsigned WIDX_P1   = 0;
  localparam int unsigned WIDX_P2   = 1;
  localparam int unsigned WIDX_STAT = 2;

  localparam logic [DATA_W-1:0] STATUS_WORD = 32'h0000_0001;

  // source button bit for each pad bit, indexed by pad bit 0..15
  localparam int unsigned SRC_MAP [PAD_W] = '{
    5, 14, 15, 4, 3, 0, 2, 1,
    12, 13, 10, 11, 6, 9, 7, 8
  };
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= '0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= '0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pad_word_map.sv
module pad_word_map
  import pad_pkg::*;
(
  input  logic [PAD_W-1:0] btn_i,
  output logic [PAD_W-1:0] pad_o
);
  generate
    for (genvar k = 0; k < PAD_W; k++) begin : g_bit
      assign pad_o[k] = ~btn_i[SRC_MAP[k]];
    end
  endgenerate
endmodule

// File: rtl/pad_bus_if.sv
module pad_bus_if
  import pad_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h1F80_8500,
  parameter int unsigned WIN_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [PAD_W-1:0]  pad1_i,
  input  logic [PAD_W-1:0]  pad2_i,
  input  logic              pad_ok_i,
  output logic              gnt_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned OFF_W  = $clog2(WIN_BYTES);
  localparam int unsigned WIDX_W = OFF_W - 2;

  logic              hit;
  logic [WIDX_W-1:0] widx;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_lsb;

  assign hit        = (addr_i[31:OFF_W] == WIN_BASE[31:OFF_W]);
  assign widx       = addr_i[OFF_W-1:2];
  assign unused_lsb = ^addr_i[1:0];
  assign gnt_o      = req_i & hit;

  always_comb begin
    rd_mux = '0;
    if (widx == WIDX_W'(WIDX_P1)) begin
      if (pad_ok_i) rd_mux[PAD_W-1:0] = pad1_i;
    end else if (widx == WIDX_W'(WIDX_P2)) begin
      if (pad_ok_i) rd_mux[PAD_W-1:0] = pad2_i;
    end else if (widx == WIDX_W'(WIDX_STAT)) begin
      rd_mux = STATUS_WORD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= gnt_o & ~we_i;
      rdata_o  <= (gnt_o & ~we_i) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/pad_reg_bank.sv
module pad_reg_bank
  import pad_pkg::*;
#(
  parameter logic [31:0] WIN_BASE    = 32'h1F80_8500,
  parameter int unsigned WIN_BYTES   = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BTN_W-1:0]  p1_btn_i,
  input  logic [BTN_W-1:0]  p2_btn_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [31:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gnt_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);

  logic [1:0][BTN_W-1:0] btn_raw, btn_sync;
  logic [1:0][PAD_W-1:0] pad_word;
  logic [CNT_W-1:0]      fill_cnt;
  logic                  pad_ok;
  logic                  unused_bits;

  assign btn_raw[0] = p1_btn_i;
  assign btn_raw[1] = p2_btn_i;

  generate
    for (genvar p = 0; p < 2; p++) begin : g_player
      pad_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (btn_raw[p]),
        .q_o   (btn_sync[p])
      );
      pad_word_map u_map (
        .btn_i(btn_sync[p][PAD_W-1:0]),
        .pad_o(pad_word[p])
      );
    end
  endgenerate

  // hold pad words at 0 until the synchronizers have refilled after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                fill_cnt <= '0;
    else if (fill_cnt != CNT_W'(SYNC_STAGES))  fill_cnt <= fill_cnt + 1'b1;
  end
  assign pad_ok = (fill_cnt == CNT_W'(SYNC_STAGES));

  assign unused_bits = ^{btn_sync[0][BTN_W-1:PAD_W], btn_sync[1][BTN_W-1:PAD_W], wdata_i};

  pad_bus_if #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .pad1_i  (pad_word[0]),
    .pad2_i  (pad_word[1]),
    .pad_ok_i(pad_ok),
    .gnt_o   (gnt_o),
    .rvalid_o(rvalid_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/pad_reg_bank_chk.sv
module pad_reg_bank_chk #(
  parameter logic [31:0] WIN_BASE  = 32'h1F80_8500,
  parameter int unsigned WIN_BYTES = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [31:0] addr_i,
  input logic        gnt_o,
  input logic        rvalid_o,
  input logic [31:0] rdata_o
);
  localparam int unsigned OFF_W = $clog2(WIN_BYTES);

  logic in_win;
  assign in_win = (addr_i >= WIN_BASE) && (addr_i - WIN_BASE < WIN_BYTES);

  p_grant_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && in_win |-> gnt_o);
  p_grant_out_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && in_win) |-> !gnt_o);
  p_rvalid_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o && !we_i |=> rvalid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gnt_o && !we_i) |=> !rvalid_o);
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == 32'h0);
  p_reserved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && ($past(addr_i[OFF_W-1:2]) > 2) |-> rdata_o == 32'h0);
  p_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && ($past(addr_i[OFF_W-1:2]) == 2) |-> rdata_o == 32'h1);
  p_hi_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> rdata_o[31:16] == 16'h0);
endmodule

bind pad_reg_bank pad_reg_bank_chk #(.WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .gnt_o   (gnt_o),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o)
);

// File: tb/pad_reg_bank_bench.sv
`timescale 1ns/1ps
module pad_reg_bank_bench;
  localparam logic [31:0] BASE = 32'h1F80_8500;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] p1_btn_i = '0, p2_btn_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        gnt_o, rvalid_o;
  logic [31:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pad_reg_bank u_pad_reg_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .p1_btn_i(p1_btn_i), .p2_btn_i(p2_btn_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .gnt_o(gnt_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  function automatic logic [31:0] exp_pad(input logic [31:0] b);
    logic [7:0] lo, hi;
    lo = ~{b[1], b[2], b[0], b[3], b[4], b[15], b[14], b[5]};
    hi = ~{b[8], b[7], b[9], b[6], b[11], b[10], b[13], b[12]};
    return {16'h0, hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic v, output logic g);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 g = gnt_o;
    @(posedge clk_i); @(negedge clk_i);
    d = rdata_o; v = rvalid_o;
    req_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, output logic v, output logic g);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    #1 g = gnt_o;
    @(posedge clk_i); @(negedge clk_i);
    v = rvalid_o;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic read_pads(input string tag);
    logic [31:0] d; logic v, g;
    rd(BASE + 32'h0, d, v, g);
    chk({tag, " p1"}, d, exp_pad(p1_btn_i));
    rd(BASE + 32'h4, d, v, g);
    chk({tag, " p2"}, d, exp_pad(p2_btn_i));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lfsr; logic v, g;

    // R10: reset state
    p1_btn_i = 32'h0000_0021; p2_btn_i = 32'h0000_0300;
    repeat (3) @(negedge clk_i);
    chk("R10 rvalid in reset", {31'h0, rvalid_o}, 32'h0);
    chk("R10 rdata in reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    rd(BASE, d, v, g);          chk("R10 p1 at edge1", d, 32'h0);
    rd(BASE + 8, d, v, g);      chk("R4 status at edge2", d, 32'h1);
    rd(BASE, d, v, g);          chk("R10 p1 at edge3", d, 32'h0000_FFDE);
    rd(BASE + 4, d, v, g);      chk("R3 p2 after fill", d, exp_pad(p2_btn_i));
    chk("R2 rvalid on read", {31'h0, v}, 32'h1);
    chk("R1 grant in window", {31'h0, g}, 32'h1);
    @(negedge clk_i);
    chk("R2 rvalid drops", {31'h0, rvalid_o}, 32'h0);
    chk("R2 rdata idle zero", rdata_o, 32'h0);

    // R7: idle inputs and upper bits ignored
    p1_btn_i = 32'h0; p2_btn_i = 32'hFFFF_0000; settle();
    read_pads("R7 upper ignored");
    rd(BASE + 4, d, v, g); chk("R7 p2 idle word", d, 32'h0000_FFFF);

    // R5/R6: walking bit on each player, other player distinct
    for (int i = 0; i < 32; i++) begin
      p1_btn_i = 32'h1 << i; p2_btn_i = 32'h0000_0C30; settle();
      read_pads(i < 8 ? "R5 walk p1" : "R6 walk p1");
      p1_btn_i = 32'h0000_5003; p2_btn_i = 32'h1 << i; settle();
      read_pads(i < 16 ? "R6 walk p2" : "R7 walk p2");
    end

    // R3/R5/R6: pseudo-random bitmaps
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 48; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      p1_btn_i = lfsr;
      p2_btn_i = {lfsr[15:0], lfsr[31:16]} ^ 32'h0000_A5C3;
      settle();
      read_pads("R3 random");
    end

    // R3: every word offset in the window
    p1_btn_i = 32'h0000_00F0; p2_btn_i = 32'h0000_0F00; settle();
    for (int w = 0; w < 64; w++) begin
      logic [31:0] e;
      e = (w == 0) ? exp_pad(p1_btn_i) : (w == 1) ? exp_pad(p2_btn_i) : (w == 2) ? 32'h1 : 32'h0;
      rd(BASE + 32'(w * 4), d, v, g);
      chk("R3 offset map", d, e);
      chk("R1 offset grant", {31'h0, g}, 32'h1);
    end

    // R9: writes everywhere are granted and ineffective
    for (int w = 0; w < 64; w++) begin
      wr(BASE + 32'(w * 4), 32'hFFFF_FFFF ^ 32'(w), v, g);
      chk("R9 write grant", {31'h0, g}, 32'h1);
      chk("R9 write no rvalid", {31'h0, v}, 32'h0);
    end
    read_pads("R9 after writes");
    rd(BASE + 8, d, v, g); chk("R9 status after writes", d, 32'h1);

    // R1: outside the window
    begin
      logic [31:0] outs [4];
      outs[0] = BASE - 4; outs[1] = BASE + 256; outs[2] = BASE ^ 32'h1000_0000; outs[3] = 32'h0;
      for (int k = 0; k < 4; k++) begin
        rd(outs[k], d, v, g);
        chk("R1 outside no grant", {31'h0, g}, 32'h0);
        chk("R2 outside no rvalid", {31'h0, v}, 32'h0);
        wr(outs[k], 32'h1234_5678, v, g);
        chk("R1 outside write no grant", {31'h0, g}, 32'h0);
      end
    end

    // R8: exact synchronizer latency, back-to-back reads
    p1_btn_i = 32'h0; settle();
    p1_btn_i = 32'h0000_0010;
    req_i = 1'b1; we_i = 1'b0; addr_i = BASE;
    @(posedge clk_i); @(negedge clk_i); chk("R8 edge1 old", rdata_o, 32'h0000_FFFF);
    @(posedge clk_i); @(negedge clk_i); chk("R8 edge2 old", rdata_o, 32'h0000_FFFF);
    @(posedge clk_i); @(negedge clk_i); chk("R8 edge3 new", rdata_o, 32'h0000_FFF7);
    req_i = 1'b0;
    @(negedge clk_i);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule